// File: doc/BRIEF.md
# Reset and Power-Good Distribution

This block turns a handful of active-low reset sources into five registered PCI reset outputs and two power-good outputs. The reset outputs form two groups. Outputs 1 to 3 follow the LPC reset and, optionally, the reset-control pin. Outputs 4 and 5 also follow the PCI reset input. Each output is driven low while any of its enabled sources is low, and goes high only when all of them are high.

Power-good is held low until the supply-valid indication has been high for a programmable delay. The delay is counted in milliseconds, and the millisecond tick is derived from the block clock by a parameterised divider. A single configuration bit decides where the reset-control pin acts. When the bit is 1, which is the reset value, the pin acts on the PCI reset outputs. When the bit is 0, the pin holds the power-good outputs low instead.

The configuration is written through a simple write strobe. The strobe captures the routing bit and the 2-bit delay code together.

Top module: `rst_pg_dist`

## Requirements
- R1: There are five active-low PCI reset outputs, `pci_rst_n[0]` to `pci_rst_n[4]`. Outputs 0..2 depend only on the LPC reset and the routed reset-control pin, and `pci_rst_in_n` has no effect on them. Outputs 0..2 are always equal to each other, and outputs 3..4 are always equal to each other.
- R2: When `lpc_rst_n` is low at a clock edge, all five reset outputs are low after that edge.
- R3: When `pci_rst_in_n` is low at a clock edge, outputs 3 and 4 are low after that edge. Outputs 0..2 are not affected.
- R4: While the routing bit is 1, a low `rstctl_n` drives all five reset outputs low one clock later, and it has no effect on `pwr_good`.
- R5: While the routing bit is 0, `rstctl_n` has no effect on the reset outputs. A low `rstctl_n` drives `pwr_good` low one clock later, and `pwr_good` returns high one clock after the pin rises, provided the delay has already elapsed.
- R6: Synchronous reset sets the routing bit to 1 and the delay code to 3 (binary 11). It also drives all reset outputs low and both `pwr_good` outputs low.
- R7: The delay code selects a delay of (code+1) x `MS_PER_STEP` milliseconds. The codes 0, 1, 2 and 3 give 100, 200, 300 and 400 ms at the default step. Suppose `supply_ok` is high for N = (code+1) x `MS_PER_STEP` x `TICKS_PER_MS` consecutive edges. Then `pwr_good` is still low after those N edges and goes high after edge N+1.
- R8: If `supply_ok` is low at an edge, `pwr_good` is low after that edge and the delay count restarts from zero. A full delay is then needed again before release.
- R9: Both `pwr_good` outputs are always equal.
- R10: A write with `cfg_we` high captures `cfg_ctl_to_rst` and `cfg_dly_code` at that edge. Routing follows the new value from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; the millisecond tick is divided from it |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_ctl_to_rst | input | 1 | Routing bit: 1 sends the reset-control pin to the PCI resets, 0 sends it to power-good |
| cfg_dly_code | input | 2 | Power-good delay code; the delay is (code+1) steps |
| rstctl_n | input | 1 | Reset-control pin, active low |
| lpc_rst_n | input | 1 | LPC bus reset, active low |
| pci_rst_in_n | input | 1 | PCI reset input, active low; feeds outputs 3 and 4 only |
| supply_ok | input | 1 | Supply detected as valid, active high |
| pci_rst_n | output | 5 | Buffered PCI reset outputs, active low |
| pwr_good | output | 2 | Delayed power-good outputs, active high |

## Verification
The assertions relate each output to the inputs sampled one edge earlier. They therefore assume the reset sources are already synchronous to `clk` and stable around the sampling edge. The bench meets this by changing every input on the falling edge only. The checker reads the captured routing bit, so a configuration write is treated as taking effect at the edge that captures it. The bench keeps `supply_ok` low while it changes the delay code, so each timed run starts from a counter that is known to be cleared.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

    localparam int unsigned NUM_RST      = 5;
    localparam int unsigned NUM_PG       = 2;
    // index of the first output that also follows the PCI reset input
    localparam int unsigned GRP_B_FIRST  = 3;
    localparam int unsigned DLY_CODE_W   = 2;

    typedef enum logic [DLY_CODE_W-1:0] {
        DLY_1_STEP = 2'd0,
        DLY_2_STEP = 2'd1,
        DLY_3_STEP = 2'd2,
        DLY_4_STEP = 2'd3
    } dly_code_e;

    typedef struct packed {
        logic      ctl_to_rst;
        dly_code_e dly;
    } rpg_cfg_t;

    localparam rpg_cfg_t CFG_RESET = '{ctl_to_rst: 1'b1, dly: DLY_4_STEP};

    typedef struct packed {
        logic rstctl_n;
        logic lpc_n;
        logic pcin_n;
    } rst_src_t;

    // level of one reset output given its sources and group
    function automatic logic rst_level(rst_src_t s, logic ctl_to_rst, logic grp_b);
        logic lvl;
        lvl = s.lpc_n;
        if (ctl_to_rst) lvl = lvl & s.rstctl_n;
        if (grp_b)      lvl = lvl & s.pcin_n;
        return lvl;
    endfunction

    function automatic int unsigned dly_steps(dly_code_e c);
        return int'(c) + 1;
    endfunction

endpackage

// File: rtl/rpg_cfg_reg.sv
module rpg_cfg_reg
    import rpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic       ctl_to_rst_wd,
    input  logic [1:0] dly_wd,
    output rpg_cfg_t   cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (we) begin
            cfg_q.ctl_to_rst <= ctl_to_rst_wd;
            cfg_q.dly        <= dly_code_e'(dly_wd);
        end
    end

endmodule

// File: rtl/rpg_ms_tick.sv
module rpg_ms_tick #(
    parameter int unsigned TICKS_PER_MS = 33
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);

    generate
        if (TICKS_PER_MS <= 1) begin : g_every_cycle
            assign tick = run;
        end else begin : g_divider
            localparam int unsigned CW = $clog2(TICKS_PER_MS);
            localparam logic [CW-1:0] LAST = CW'(TICKS_PER_MS - 1);
            logic [CW-1:0] cnt_q;

            assign tick = run && (cnt_q == LAST);

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rpg_pg_timer.sv
module rpg_pg_timer
    import rpg_pkg::*;
#(
    parameter int unsigned TICKS_PER_MS = 33,
    parameter int unsigned MS_PER_STEP  = 100
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      supply_ok,
    input  dly_code_e dly,
    output logic      done
);

    localparam int unsigned MAX_MS = 4 * MS_PER_STEP;
    localparam int unsigned MS_W   = $clog2(MAX_MS + 1);

    logic            tick;
    logic [MS_W-1:0] ms_q;
    logic [MS_W-1:0] target;

    rpg_ms_tick #(.TICKS_PER_MS(TICKS_PER_MS)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (supply_ok),
        .tick (tick)
    );

    assign target = MS_W'(dly_steps(dly) * MS_PER_STEP);
    assign done   = supply_ok && (ms_q >= target);

    always_ff @(posedge clk) begin
        if (rst || !supply_ok) begin
            ms_q <= '0;
        end else if (tick && (ms_q < target)) begin
            ms_q <= ms_q + 1'b1;
        end
    end

endmodule

// File: rtl/rpg_rst_fanout.sv
module rpg_rst_fanout
    import rpg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  rst_src_t           src,
    input  logic               ctl_to_rst,
    output logic [NUM_RST-1:0] rst_out_n
);

    generate
        for (genvar i = 0; i < NUM_RST; i++) begin : g_out
            localparam logic IN_B = (i >= GRP_B_FIRST);
            always_ff @(posedge clk) begin
                if (rst) begin
                    rst_out_n[i] <= 1'b0;
                end else begin
                    rst_out_n[i] <= rst_level(src, ctl_to_rst, IN_B);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rst_pg_dist.sv
module rst_pg_dist
    import rpg_pkg::*;
#(
    parameter int unsigned TICKS_PER_MS = 33,
    parameter int unsigned MS_PER_STEP  = 100
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic                 cfg_ctl_to_rst,
    input  logic [1:0]           cfg_dly_code,
    input  logic                 rstctl_n,
    input  logic                 lpc_rst_n,
    input  logic                 pci_rst_in_n,
    input  logic                 supply_ok,
    output logic [NUM_RST-1:0]   pci_rst_n,
    output logic [NUM_PG-1:0]    pwr_good
);

    rpg_cfg_t cfg_q;
    rst_src_t src;
    logic     ctl_to_rst_q;
    logic     dly_done;
    logic     pg_next;

    rpg_cfg_reg u_cfg (
        .clk           (clk),
        .rst           (rst),
        .we            (cfg_we),
        .ctl_to_rst_wd (cfg_ctl_to_rst),
        .dly_wd        (cfg_dly_code),
        .cfg_q         (cfg_q)
    );

    assign ctl_to_rst_q = cfg_q.ctl_to_rst;
    assign src = '{rstctl_n: rstctl_n, lpc_n: lpc_rst_n, pcin_n: pci_rst_in_n};

    rpg_rst_fanout u_fan (
        .clk        (clk),
        .rst        (rst),
        .src        (src),
        .ctl_to_rst (ctl_to_rst_q),
        .rst_out_n  (pci_rst_n)
    );

    rpg_pg_timer #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .MS_PER_STEP  (MS_PER_STEP)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .dly       (cfg_q.dly),
        .done      (dly_done)
    );

    // reset-control pin gates power-good only when routed away from resets
    assign pg_next = dly_done && (ctl_to_rst_q || rstctl_n);

    generate
        for (genvar p = 0; p < NUM_PG; p++) begin : g_pg
            always_ff @(posedge clk) begin
                if (rst) pwr_good[p] <= 1'b0;
                else     pwr_good[p] <= pg_next;
            end
        end
    endgenerate

endmodule

// File: rtl/rpg_chk.sv
module rpg_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctl_to_rst_q,
    input logic       rstctl_n,
    input logic       lpc_rst_n,
    input logic       pci_rst_in_n,
    input logic       supply_ok,
    input logic [4:0] pci_rst_n,
    input logic [1:0] pwr_good
);

    // R1
    grp_a_equal_chk: assert property (@(posedge clk) disable iff (rst)
        (pci_rst_n[2:0] == 3'b000) || (pci_rst_n[2:0] == 3'b111));

    // R1
    grp_b_equal_chk: assert property (@(posedge clk) disable iff (rst)
        pci_rst_n[3] == pci_rst_n[4]);

    // R2
    lpc_asserts_all_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(lpc_rst_n) |-> (pci_rst_n == 5'b00000));

    // R3
    pcin_asserts_grp_b_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(pci_rst_in_n) |-> (pci_rst_n[4:3] == 2'b00));

    // R4
    ctl_to_rst_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ctl_to_rst_q) && !$past(rstctl_n)) |-> (pci_rst_n == 5'b00000));

    // R5
    ctl_to_pg_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(ctl_to_rst_q) && !$past(rstctl_n)) |-> (pwr_good == 2'b00));

    // R8
    supply_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(supply_ok) |-> (pwr_good == 2'b00));

    // R9
    pg_pair_equal_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_good[0] == pwr_good[1]);

endmodule

bind rst_pg_dist rpg_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ctl_to_rst_q (ctl_to_rst_q),
    .rstctl_n     (rstctl_n),
    .lpc_rst_n    (lpc_rst_n),
    .pci_rst_in_n (pci_rst_in_n),
    .supply_ok    (supply_ok),
    .pci_rst_n    (pci_rst_n),
    .pwr_good     (pwr_good)
);

// File: tb/rst_pg_dist_tb.sv
module rst_pg_dist_tb;

    localparam int unsigned TPM  = 2;
    localparam int unsigned STEP = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic       cfg_ctl_to_rst = 1'b1;
    logic [1:0] cfg_dly_code = 2'd3;
    logic       rstctl_n = 1'b1;
    logic       lpc_rst_n = 1'b1;
    logic       pci_rst_in_n = 1'b1;
    logic       supply_ok = 1'b0;
    logic [4:0] pci_rst_n;
    logic [1:0] pwr_good;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    rst_pg_dist #(.TICKS_PER_MS(TPM), .MS_PER_STEP(STEP)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .cfg_we         (cfg_we),
        .cfg_ctl_to_rst (cfg_ctl_to_rst),
        .cfg_dly_code   (cfg_dly_code),
        .rstctl_n       (rstctl_n),
        .lpc_rst_n      (lpc_rst_n),
        .pci_rst_in_n   (pci_rst_in_n),
        .supply_ok      (supply_ok),
        .pci_rst_n      (pci_rst_n),
        .pwr_good       (pwr_good)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(logic route, logic [1:0] code);
        cfg_we = 1'b1; cfg_ctl_to_rst = route; cfg_dly_code = code;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    function automatic logic [4:0] exp_rst(logic route, logic ctl, logic lpc, logic pin);
        logic a, b;
        a = lpc & (route ? ctl : 1'b1);
        b = a & pin;
        return {b, b, a, a, a};
    endfunction

    // raise supply from a cleared counter and check the release edge
    task automatic timed_release(string req, int unsigned code);
        int unsigned n;
        n = (code + 1) * STEP * TPM;
        supply_ok = 1'b1;
        cyc(n);
        check(req, {6'd0, pwr_good}, 8'h00);
        cyc(1);
        check(req, {6'd0, pwr_good}, 8'h03);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R6 reset state
        check("R6", {3'd0, pci_rst_n}, 8'h00);
        check("R6", {6'd0, pwr_good}, 8'h00);
        rst = 1'b0;
        cyc(1);
        check("R6", {3'd0, pci_rst_n}, 8'h1f);

        // R1..R4, R10: exhaustive source sweep in both routings
        for (int r = 1; r >= 0; r--) begin
            if (r == 0) wr_cfg(1'b0, 2'd3);
            for (int v = 0; v < 8; v++) begin
                rstctl_n = v[2]; lpc_rst_n = v[1]; pci_rst_in_n = v[0];
                cyc(1);
                check(r ? "R4 R1 R2 R3" : "R5 R10 R1 R2 R3", {3'd0, pci_rst_n},
                      {3'd0, exp_rst(r[0], v[2], v[1], v[0])});
            end
        end
        rstctl_n = 1'b1; lpc_rst_n = 1'b1; pci_rst_in_n = 1'b1;
        wr_cfg(1'b1, 2'd3);
        cyc(1);

        // R6 default delay code 3, R7 release timing
        supply_ok = 1'b0; cyc(1);
        timed_release("R6 R7", 3);

        // R4: pin routed to resets leaves power-good alone
        rstctl_n = 1'b0; cyc(1);
        check("R4", {6'd0, pwr_good}, 8'h03);
        check("R4", {3'd0, pci_rst_n}, 8'h00);
        rstctl_n = 1'b1; cyc(1);

        // R5: pin routed to power-good
        wr_cfg(1'b0, 2'd3);
        rstctl_n = 1'b0; cyc(1);
        check("R5", {6'd0, pwr_good}, 8'h00);
        check("R5", {3'd0, pci_rst_n}, 8'h1f);
        rstctl_n = 1'b1; cyc(1);
        check("R5", {6'd0, pwr_good}, 8'h03);
        wr_cfg(1'b1, 2'd3);

        // R8: one-cycle supply drop, then full delay again
        supply_ok = 1'b0; cyc(1);
        check("R8", {6'd0, pwr_good}, 8'h00);
        timed_release("R8", 3);

        // R7: sweep every delay code
        for (int c = 0; c < 4; c++) begin
            supply_ok = 1'b0; cyc(1);
            wr_cfg(1'b1, c[1:0]);
            timed_release("R7", c);
        end

        // R8: drop mid-count restarts from zero
        supply_ok = 1'b0; cyc(1);
        wr_cfg(1'b1, 2'd1);
        supply_ok = 1'b1; cyc(5);
        supply_ok = 1'b0; cyc(1);
        check("R8", {6'd0, pwr_good}, 8'h00);
        timed_release("R8", 1);

        // R6: reset re-applied restores defaults
        rst = 1'b1; cyc(1);
        check("R6", {6'd0, pwr_good}, 8'h00);
        check("R6", {3'd0, pci_rst_n}, 8'h00);
        rst = 1'b0; supply_ok = 1'b0; cyc(1);
        timed_release("R6", 3);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule